// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM that serves as a processor's secondary cache data store. Each word is split into four 9-bit byte lanes. The address, write data and write controls are taken in on the rising clock edge. Two asynchronous inputs act outside the clock: the output enable, and the selector that chooses the burst order.

A burst opens when either of two active-low address strobes is asserted. One strobe is meant for the processor and the other for the cache controller. The cycle that opens the burst loads the external address. After that, a 2-bit beat counter supplies the two low address bits and moves on only in cycles where the advance input is low. The order of the beats is either linear or interleaved. Writes go into the array at the same clock edge that registers them. Reads pass through an output register, so read data appears one edge after the registered address. A separate valid signal stands in for a tri-state data output.

Top module: `pipe_burst_sram`

## Requirements
- R1: The array depth is 2^ADDR_W words; the full-size configuration uses ADDR_W = 17. The data width is LANES × LANE_W = 4 × 9. Lane k occupies data bits [9k+8 : 9k].
- R2: A cycle in which procStrobeN or ctlStrobeN is low loads addrIn as the burst start. This applies even when advanceN is also low. When both strobes are low together, the cycle follows the rules of procStrobeN.
- R3: With burstLinear = 1, the two low address bits of beat n are (start + n) mod 4.
- R4: The beat counter steps only on a cycle with no strobe and advanceN low. Address bits above bit 1 never change inside a burst. A cycle with advanceN high keeps the current address.
- R5: With burstLinear = 0, the two low address bits of beat n are start XOR n. burstLinear acts asynchronously on the current address.
- R6: A cycle opened by procStrobeN is always a read. The write inputs have no effect in that cycle.
- R7: In any other cycle where wrEnN is low, lane k is written if laneWrN[k] is low. The other lanes keep their contents.
- R8: When globalWrN is low, all four lanes are written, whatever wrEnN and laneWrN are (except in a procStrobeN cycle).
- R9: Data for a read address registered at edge E is presented on dOut after edge E+1.
- R10: A write takes effect at the edge that registers it. A read of the same word registered at the next edge returns the new data.
- R11: dOutValid is 0 whenever outEnN is high, and it follows outEnN without waiting for a clock. It is also 0 during the cycle after a write is registered, and after reset until the first read result.
- R12: When advance is held, the burst wraps inside its 4-word block and repeats from the start value after four beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of control state |
| addrIn | input | ADDR_W | External word address |
| dIn | input | 36 | Write data |
| procStrobeN | input | 1 | Active-low processor burst start (read only) |
| ctlStrobeN | input | 1 | Active-low controller burst start |
| advanceN | input | 1 | Active-low burst advance |
| wrEnN | input | 1 | Active-low write enable for lane writes |
| globalWrN | input | 1 | Active-low write of all lanes |
| laneWrN | input | 4 | Active-low per-lane write selects |
| burstLinear | input | 1 | 1 = linear order, 0 = interleaved (asynchronous) |
| outEnN | input | 1 | Active-low output enable (asynchronous) |
| dOut | output | 36 | Registered read data |
| dOutValid | output | 1 | High when dOut is actively driven |

## Verification
The functions most likely to collide are burst start and burst advance, since a strobe and a low advanceN can arrive in the same cycle. A second collision is between the two strobes when a processor strobe arrives with write controls asserted. Directed cycles drive both strobes, the advance input and every write input together. A reference model, which applies start-over-advance and read-only-processor-cycle precedence, is then compared with the data read back through the pipeline. Random stimulus hits the same overlaps repeatedly with the order selector changing, and each visible output word is judged against the reference array.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  localparam int LANES = 4;

  typedef struct packed {
    logic             writeEn;
    logic             captureRead;
    logic [LANES-1:0] laneMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctlStrobeN,
  input  logic              advanceN,
  input  logic              wrEnN,
  input  logic              globalWrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstLinear,
  output ctrlStrobes_t      strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              curWrite
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] baseHi, nextHi;
  logic [1:0]      startLow, nextStart;
  logic [1:0]      beatCnt, nextCnt;
  logic            active;
  logic            anyStrobe;
  logic            writeReq;

  function automatic logic [1:0] beatLow(input logic [1:0] s, input logic [1:0] c,
                                         input logic lin);
    return lin ? 2'(s + c) : (s ^ c);
  endfunction

  always_comb begin
    anyStrobe = ~procStrobeN | ~ctlStrobeN;
    nextHi    = anyStrobe ? addrIn[ADDR_W-1:2] : baseHi;
    nextStart = anyStrobe ? addrIn[1:0] : startLow;
    if (anyStrobe)      nextCnt = 2'd0;
    else if (!advanceN) nextCnt = 2'(beatCnt + 2'd1);
    else                nextCnt = beatCnt;
    wrAddr = {nextHi, beatLow(nextStart, nextCnt, burstLinear)};
    rdAddr = {baseHi, beatLow(startLow, beatCnt, burstLinear)};
  end

  always_comb begin
    writeReq         = (anyStrobe | active) & procStrobeN & (~globalWrN | ~wrEnN);
    strb.writeEn     = writeReq;
    strb.captureRead = active & ~curWrite;
    if (!writeReq)       strb.laneMask = '0;
    else if (!globalWrN) strb.laneMask = '1;
    else                 strb.laneMask = ~laneWrN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi   <= '0;
      startLow <= 2'd0;
      beatCnt  <= 2'd0;
      active   <= 1'b0;
      curWrite <= 1'b0;
    end else begin
      baseHi   <= nextHi;
      startLow <= nextStart;
      beatCnt  <= nextCnt;
      active   <= active | anyStrobe;
      curWrite <= writeReq;
    end
  end

  assert_proc_read_R6 : assert property (@(posedge clk) disable iff (!rstN)
    !procStrobeN |-> !strb.writeEn);

  assert_strobe_load_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN || !ctlStrobeN) |=> rdAddr[ADDR_W-1:2] == $past(addrIn[ADDR_W-1:2]));

  assert_upper_fixed_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && ctlStrobeN) |=> $stable(rdAddr[ADDR_W-1:2]));

  assert_global_lanes_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (!globalWrN && procStrobeN && (active || !ctlStrobeN)) |-> (strb.writeEn && &strb.laneMask));
endmodule

// File: rtl/sram_burst_datapath.sv
module sram_burst_datapath
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strb,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic                    curWrite,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutValid
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] outReg;
  logic              outFull;

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (strb.writeEn && strb.laneMask[k])
        mem[wrAddr][k*LANE_W +: LANE_W] <= dIn[k*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) outReg <= mem[rdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) outFull <= 1'b0;
    else       outFull <= strb.captureRead;
  end

  assign dOut      = outReg;
  assign dOutValid = ~outEnN & outFull & ~curWrite;

  assert_oe_off_R11 : assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dOutValid);

  assert_write_hides_R11 : assert property (@(posedge clk) disable iff (!rstN)
    strb.writeEn |=> !dOutValid);
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    procStrobeN,
  input  logic                    ctlStrobeN,
  input  logic                    advanceN,
  input  logic                    wrEnN,
  input  logic                    globalWrN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    burstLinear,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutValid
);
  ctrlStrobes_t      strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic              curWrite;

  sram_burst_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctlStrobeN(ctlStrobeN), .advanceN(advanceN),
    .wrEnN(wrEnN), .globalWrN(globalWrN), .laneWrN(laneWrN),
    .burstLinear(burstLinear), .strb(strb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .curWrite(curWrite)
  );

  sram_burst_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .curWrite(curWrite), .dIn(dIn), .outEnN(outEnN),
    .dOut(dOut), .dOutValid(dOutValid)
  );
endmodule

// File: tb/pipe_burst_sram_tb_top.sv
module pipe_burst_sram_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 10;
  localparam int DW     = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DW-1:0] dIn = '0;
  logic procStrobeN = 1'b1, ctlStrobeN = 1'b1, advanceN = 1'b1;
  logic wrEnN = 1'b1, globalWrN = 1'b1, burstLinear = 1'b1, outEnN = 1'b0;
  logic [3:0] laneWrN = 4'hF;
  logic [DW-1:0] dOut;
  logic dOutValid;

  int testCnt = 0;
  int failCnt = 0;
  string curTag = "R9 reset";

  always #(CLK_P/2) clk = ~clk;

  pipe_burst_sram #(.ADDR_W(ADDR_W), .LANE_W(9)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dIn(dIn),
    .procStrobeN(procStrobeN), .ctlStrobeN(ctlStrobeN), .advanceN(advanceN),
    .wrEnN(wrEnN), .globalWrN(globalWrN), .laneWrN(laneWrN),
    .burstLinear(burstLinear), .outEnN(outEnN), .dOut(dOut), .dOutValid(dOutValid)
  );

  // Reference model state
  logic [DW-1:0] refMem [64];
  logic [ADDR_W-1:0] mBase, mRd, mWr;
  logic [1:0] mStart, mCnt;
  logic mActive = 0, mCurWrite = 0, mOutFull = 0, mStrobe, mWrite;
  logic [DW-1:0] mOutData = '0;
  logic [3:0] mMask;

  function automatic logic [1:0] expLow(input logic [1:0] s, input logic [1:0] c, input logic lin);
    return lin ? 2'(s + c) : (s ^ c);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mCurWrite = 0; mOutFull = 0; mCnt = 0; mStart = 0; mBase = '0;
    end else begin
      mStrobe = !procStrobeN || !ctlStrobeN;
      mRd = {mBase[ADDR_W-1:2], expLow(mStart, mCnt, burstLinear)};
      mOutData = refMem[mRd[5:0]];
      mOutFull = mActive && !mCurWrite;
      if (mStrobe) begin mBase = addrIn; mStart = addrIn[1:0]; mCnt = 0; end
      else if (!advanceN) mCnt = 2'(mCnt + 2'd1);
      mWr = {mBase[ADDR_W-1:2], expLow(mStart, mCnt, burstLinear)};
      mWrite = (mStrobe || mActive) && procStrobeN && (!globalWrN || !wrEnN);
      mMask = !globalWrN ? 4'hF : ~laneWrN;
      if (mWrite)
        for (int k = 0; k < 4; k++)
          if (mMask[k]) refMem[mWr[5:0]][k*9 +: 9] = dIn[k*9 +: 9];
      mCurWrite = mWrite;
      mActive = mActive || mStrobe;
    end
  end

  task automatic checkOut();
    logic expV;
    expV = !outEnN && mOutFull && !mCurWrite;
    testCnt++;
    if (dOutValid !== expV) begin
      failCnt++;
      $display("FAIL %s: dOutValid=%0b expected %0b", curTag, dOutValid, expV);
    end else if (expV) begin
      testCnt++;
      if (dOut !== mOutData) begin
        failCnt++;
        $display("FAIL %s: dOut=%h expected %h", curTag, dOut, mOutData);
      end
    end
  endtask

  task automatic step(input logic pN, input logic cN, input logic aN, input logic wN,
                      input logic gN, input logic [3:0] lN, input logic [ADDR_W-1:0] a,
                      input logic [DW-1:0] d);
    procStrobeN = pN; ctlStrobeN = cN; advanceN = aN; wrEnN = wN;
    globalWrN = gN; laneWrN = lN; addrIn = a; dIn = d;
    @(negedge clk);
    checkOut();
  endtask

  function automatic logic [DW-1:0] rnd36();
    return {4'($urandom), $urandom};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    testCnt++;
    if (dOutValid !== 1'b0) begin
      failCnt++; $display("FAIL R11 reset: dOutValid=%0b expected 0", dOutValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    checkOut();

    // R1 R8: fill with global writes, lane data distinct per lane
    curTag = "R1 R8 global fill";
    for (int i = 0; i < 64; i++)
      step(1, 0, 1, 1, 0, 4'hF, ADDR_W'(i), rnd36());

    // R3 R5 R12: every start value, both orders, six advancing beats (wraps)
    for (int lin = 0; lin < 2; lin++)
      for (int s = 0; s < 4; s++) begin
        burstLinear = 1'(lin);
        curTag = lin ? "R3 R12 linear burst" : "R5 R12 interleaved burst";
        step(0, 1, 1, 1, 1, 4'hF, ADDR_W'(16 + s), '0);
        for (int b = 0; b < 6; b++) step(1, 1, 0, 1, 1, 4'hF, '0, '0);
        step(1, 1, 1, 1, 1, 4'hF, '0, '0);
      end

    // R4: hold without advance
    curTag = "R4 hold";
    step(0, 1, 1, 1, 1, 4'hF, ADDR_W'(41), '0);
    for (int b = 0; b < 4; b++) step(1, 1, 1, 1, 1, 4'hF, ADDR_W'(7), '0);

    // R7 R1: each single lane written, then read back
    for (int k = 0; k < 4; k++) begin
      curTag = "R7 R1 single lane";
      step(1, 0, 1, 0, 1, ~(4'b1 << k), ADDR_W'(8 + k), rnd36());
      step(0, 1, 1, 1, 1, 4'hF, ADDR_W'(8 + k), '0);
      step(1, 1, 1, 1, 1, 4'hF, '0, '0);
    end

    // R8: global overrides disabled wrEnN and lane selects
    curTag = "R8 global override";
    step(1, 0, 1, 1, 0, 4'hF, ADDR_W'(30), rnd36());
    step(0, 1, 1, 1, 1, 4'hF, ADDR_W'(30), '0);
    step(1, 1, 1, 1, 1, 4'hF, '0, '0);

    // R6: processor strobe with all write inputs asserted is a read
    curTag = "R6 proc strobe read";
    step(0, 1, 1, 0, 0, 4'h0, ADDR_W'(31), rnd36());
    step(0, 1, 1, 1, 1, 4'hF, ADDR_W'(31), '0);
    step(1, 1, 1, 1, 1, 4'hF, '0, '0);

    // R2: both strobes plus advance in one cycle
    curTag = "R2 strobe precedence";
    step(0, 0, 0, 0, 0, 4'h0, ADDR_W'(50), rnd36());
    step(1, 1, 1, 1, 1, 4'hF, '0, '0);
    step(1, 1, 1, 1, 1, 4'hF, '0, '0);

    // R10: write then immediate read of same word
    curTag = "R10 read after write";
    step(1, 0, 1, 1, 0, 4'hF, ADDR_W'(12), rnd36());
    step(0, 1, 1, 1, 1, 4'hF, ADDR_W'(12), '0);
    step(1, 1, 1, 1, 1, 4'hF, '0, '0);

    // R11: asynchronous output enable
    curTag = "R11 async enable";
    outEnN = 1'b1; #1; checkOut();
    outEnN = 1'b0; #1; checkOut();
    step(1, 1, 1, 1, 1, 4'hF, '0, '0);

    // R9 R10 random mix
    curTag = "R9 R10 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic pN, cN, aN, wN, gN;
      r = int'($urandom % 10);
      pN = (r < 2) ? 1'b0 : 1'b1;
      cN = (r >= 2 && r < 4) ? 1'b0 : 1'b1;
      aN = 1'($urandom % 2);
      wN = ($urandom % 4 == 0) ? 1'b0 : 1'b1;
      gN = ($urandom % 8 == 0) ? 1'b0 : 1'b1;
      burstLinear = 1'($urandom % 2);
      outEnN = ($urandom % 8 == 0) ? 1'b1 : 1'b0;
      step(pN, cN, aN, wN, gN, 4'($urandom), ADDR_W'($urandom % 64), rnd36());
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    failCnt++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule